// File: doc/BRIEF.md
# SIMD Instruction Fault Qualifier

This block decides, in a single combinational step, whether a packed-integer SIMD instruction may go ahead or which fault it must raise. Its inputs are the instruction's operand width (narrow 64-bit or wide 128-bit), whether it has a memory operand and at what effective address, a lock-prefix flag, and the machine state: an emulation bit, a task-switched bit, an OS extended-state support bit, a vector-feature support bit, a pending legacy-FPU-exception flag, the alignment-check enable and the current privilege level.

The result is a five-bit one-hot fault vector and an execute-permitted signal. Bit 0 is undefined opcode, bit 1 is device not available, bit 2 is FPU fault, bit 3 is general protection and bit 4 is alignment check. When more than one fault applies, only the one with the highest priority is reported. Bit 0 has the highest priority and bit 4 the lowest. Paging, segment-limit and canonical-address checks are handled elsewhere in the pipeline. The issue stage uses this block to gate dispatch.

Top module: `simd_fault_qual`

## Requirements
- R1: With valid_i high, lock_i high raises undefined opcode (fault_o = 5'b00001) for both operand widths.
- R2: With valid_i high, emul_i high raises undefined opcode for both operand widths.
- R3: For a wide operation (wide_i=1), os_xstate_i low or simd_ok_i low raises undefined opcode. For a narrow operation, both inputs have no effect on fault_o.
- R4: With valid_i high and no undefined-opcode condition, task_sw_i high raises device not available (fault_o = 5'b00010).
- R5: For a narrow operation, fpu_pend_i high raises FPU fault (5'b00100) when no higher fault applies. For a wide operation, fpu_pend_i has no effect.
- R6: For a wide operation with mem_i high, an address whose low four bits are not all zero raises general protection (5'b01000), whatever ac_en_i and cpl_i are. With mem_i low, the address has no effect.
- R7: For a narrow operation with mem_i high, an address whose low three bits are not all zero raises alignment check (5'b10000) only when ac_en_i is high and cpl_i is 3. Otherwise it raises no fault.
- R8: fault_o has at most one bit set. If several faults apply, the lowest-numbered one wins: undefined opcode, then device not available, then FPU fault, then general protection, then alignment check.
- R9: With valid_i low, fault_o is zero and exec_o is low. With valid_i high, exec_o is high exactly when fault_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| valid_i | input | 1 | An instruction is presented for qualification |
| wide_i | input | 1 | 1: 128-bit operands, 0: 64-bit operands |
| mem_i | input | 1 | Source operand comes from memory |
| addr_i | input | ADDR_W | Effective address of the memory operand |
| lock_i | input | 1 | Lock prefix present |
| emul_i | input | 1 | Emulation control bit (control word bit 2) |
| task_sw_i | input | 1 | Task-switched control bit (control word bit 3) |
| os_xstate_i | input | 1 | OS extended-state support bit (bit 9) |
| simd_ok_i | input | 1 | Processor supports the wide vector feature |
| fpu_pend_i | input | 1 | A legacy FPU exception is pending |
| ac_en_i | input | 1 | Alignment checking enabled |
| cpl_i | input | CPL_W | Current privilege level |
| fault_o | output | 5 | One-hot fault code, bit order as in R8 |
| exec_o | output | 1 | Instruction may execute |

## Verification
Each fault source is first driven on its own at both operand widths. This shows which conditions depend on width and which do not. Addresses are walked through aligned values, offsets that are misaligned only at 16 bytes, and offsets that are misaligned at 8 bytes. These patterns separate the 8-byte rule from the 16-byte rule, and the mem_i gate from the address itself. The enable and privilege inputs of the alignment check are then swept one at a time. Finally, faults are stacked in pairs and all together, which shows that the priority order is kept and that the output is one-hot.

// File: rtl/simd_fq_pkg.sv
package simd_fq_pkg;
   localparam int FLT_N       = 5;
   localparam int FLT_UNDEF   = 0;
   localparam int FLT_NODEV   = 1;
   localparam int FLT_FPUERR  = 2;
   localparam int FLT_GENPROT = 3;
   localparam int FLT_ALIGN   = 4;
   typedef logic [FLT_N-1:0] flt_vec_t;
endpackage

// File: rtl/simd_fq_misalign.sv
module simd_fq_misalign #(
   parameter int ADDR_W      = 64,
   parameter int ALIGN_BYTES = 16
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              misaligned
);
   localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(ALIGN_BYTES - 1);

   if ((ALIGN_BYTES & (ALIGN_BYTES - 1)) != 0) begin : g_bad_align
      $error("ALIGN_BYTES must be a power of two");
   end

   assign misaligned = |(addr & LOW_MASK);
endmodule

// File: rtl/simd_fq_prio.sv
module simd_fq_prio #(
   parameter int N = 5
) (
   input  logic [N-1:0] raw,
   output logic [N-1:0] grant
);
   logic [N-1:0] seen;

   assign seen[0]  = 1'b0;
   assign grant[0] = raw[0];

   for (genvar i = 1; i < N; i++) begin : g_stage
      assign seen[i]  = seen[i-1] | raw[i-1];
      assign grant[i] = raw[i] & ~seen[i];
   end
endmodule

// File: rtl/simd_fq_cond.sv
module simd_fq_cond
   import simd_fq_pkg::*;
#(
   parameter int ADDR_W       = 64,
   parameter int CPL_W        = 2,
   parameter int WIDE_BYTES   = 16,
   parameter int NARROW_BYTES = 8
) (
   input  logic              wide,
   input  logic              mem,
   input  logic [ADDR_W-1:0] addr,
   input  logic              lock,
   input  logic              emul,
   input  logic              task_sw,
   input  logic              os_xstate,
   input  logic              simd_ok,
   input  logic              fpu_pend,
   input  logic              ac_en,
   input  logic [CPL_W-1:0]  cpl,
   output flt_vec_t          raw
);
   localparam logic [CPL_W-1:0] USER_CPL = {CPL_W{1'b1}};

   logic mis_wide;
   logic mis_narrow;

   simd_fq_misalign #(.ADDR_W(ADDR_W), .ALIGN_BYTES(WIDE_BYTES)) u_mis_wide (
      .addr       (addr),
      .misaligned (mis_wide)
   );

   simd_fq_misalign #(.ADDR_W(ADDR_W), .ALIGN_BYTES(NARROW_BYTES)) u_mis_narrow (
      .addr       (addr),
      .misaligned (mis_narrow)
   );

   always_comb begin
      raw              = '0;
      raw[FLT_UNDEF]   = lock | emul | (wide & (~os_xstate | ~simd_ok));
      raw[FLT_NODEV]   = task_sw;
      raw[FLT_FPUERR]  = ~wide & fpu_pend;
      raw[FLT_GENPROT] = wide & mem & mis_wide;
      raw[FLT_ALIGN]   = ~wide & mem & mis_narrow & ac_en & (cpl == USER_CPL);
   end
endmodule

// File: rtl/simd_fault_qual.sv
module simd_fault_qual
   import simd_fq_pkg::*;
#(
   parameter int ADDR_W       = 64,
   parameter int CPL_W        = 2,
   parameter int WIDE_BYTES   = 16,
   parameter int NARROW_BYTES = 8
) (
   input  logic              valid_i,
   input  logic              wide_i,
   input  logic              mem_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              lock_i,
   input  logic              emul_i,
   input  logic              task_sw_i,
   input  logic              os_xstate_i,
   input  logic              simd_ok_i,
   input  logic              fpu_pend_i,
   input  logic              ac_en_i,
   input  logic [CPL_W-1:0]  cpl_i,
   output logic [FLT_N-1:0]  fault_o,
   output logic              exec_o
);
   if (ADDR_W < $clog2(WIDE_BYTES) + 1) begin : g_bad_addr
      $error("ADDR_W too narrow for the wide alignment check");
   end
   if (NARROW_BYTES > WIDE_BYTES) begin : g_bad_order
      $error("NARROW_BYTES must not exceed WIDE_BYTES");
   end

   flt_vec_t raw;
   flt_vec_t grant;

   simd_fq_cond #(
      .ADDR_W(ADDR_W), .CPL_W(CPL_W),
      .WIDE_BYTES(WIDE_BYTES), .NARROW_BYTES(NARROW_BYTES)
   ) u_cond (
      .wide      (wide_i),
      .mem       (mem_i),
      .addr      (addr_i),
      .lock      (lock_i),
      .emul      (emul_i),
      .task_sw   (task_sw_i),
      .os_xstate (os_xstate_i),
      .simd_ok   (simd_ok_i),
      .fpu_pend  (fpu_pend_i),
      .ac_en     (ac_en_i),
      .cpl       (cpl_i),
      .raw       (raw)
   );

   simd_fq_prio #(.N(FLT_N)) u_prio (
      .raw   (raw),
      .grant (grant)
   );

   assign fault_o = valid_i ? grant : '0;
   assign exec_o  = valid_i & ~|raw;
endmodule

// File: rtl/simd_fault_qual_chk.sv
module simd_fault_qual_chk
   import simd_fq_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int CPL_W  = 2
) (
   input logic              valid_i,
   input logic              wide_i,
   input logic              mem_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic              lock_i,
   input logic              emul_i,
   input logic              task_sw_i,
   input logic              os_xstate_i,
   input logic              simd_ok_i,
   input logic              fpu_pend_i,
   input logic              ac_en_i,
   input logic [CPL_W-1:0]  cpl_i,
   input logic [FLT_N-1:0]  fault_o,
   input logic              exec_o
);
   logic top_ud;
   assign top_ud = lock_i | emul_i | (wide_i & (~os_xstate_i | ~simd_ok_i));

   always_comb begin
      a_r8_onehot: assert ($onehot0(fault_o));
      a_r9_idle: assert (valid_i || (fault_o == '0 && !exec_o));
      a_r9_exec: assert (!valid_i || (exec_o == (fault_o == '0)));
      a_r1_lock: assert (!(valid_i && lock_i) || fault_o[FLT_UNDEF]);
      a_r2_emul: assert (!(valid_i && emul_i) || fault_o[FLT_UNDEF]);
      a_r3_wide_support: assert (!(valid_i && wide_i && !(os_xstate_i && simd_ok_i))
                                 || fault_o[FLT_UNDEF]);
      a_r4_task_sw: assert (!(valid_i && task_sw_i && !top_ud) || fault_o[FLT_NODEV]);
      a_r5_fpu_narrow: assert (!fault_o[FLT_FPUERR] || (!wide_i && fpu_pend_i));
      a_r6_wide_gp: assert (!fault_o[FLT_GENPROT]
                            || (wide_i && mem_i && (addr_i & ADDR_W'(15)) != '0));
      a_r7_narrow_ac: assert (!fault_o[FLT_ALIGN]
                              || (!wide_i && mem_i && ac_en_i && (&cpl_i)
                                  && (addr_i & ADDR_W'(7)) != '0));
   end
endmodule

bind simd_fault_qual simd_fault_qual_chk #(.ADDR_W(ADDR_W), .CPL_W(CPL_W)) u_chk (.*);

// File: tb/test_simd_fault_qual.sv
module test_simd_fault_qual;
   localparam int AW = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          valid, wide, mem, lock, emul, tsw, osx, sok, fpp, acen;
   logic [AW-1:0] addr;
   logic [1:0]    cpl;
   logic [4:0]    fault;
   logic          exec;

   int n_chk = 0;
   int n_fail = 0;

   simd_fault_qual i_simd_fault_qual (
      .valid_i(valid), .wide_i(wide), .mem_i(mem), .addr_i(addr),
      .lock_i(lock), .emul_i(emul), .task_sw_i(tsw), .os_xstate_i(osx),
      .simd_ok_i(sok), .fpu_pend_i(fpp), .ac_en_i(acen), .cpl_i(cpl),
      .fault_o(fault), .exec_o(exec)
   );

   task automatic check(input string tag, input logic [4:0] exp_f, input logic exp_e);
      n_chk++;
      if (fault !== exp_f || exec !== exp_e) begin
         n_fail++;
         $display("FAIL %s: fault=%b exec=%b expected fault=%b exec=%b",
                  tag, fault, exec, exp_f, exp_e);
      end
   endtask

   task automatic clean(input logic w);
      @(negedge clk);
      valid = 1'b1; wide = w; mem = 1'b0; addr = '0; lock = 1'b0;
      emul = 1'b0; tsw = 1'b0; osx = 1'b1; sok = 1'b1; fpp = 1'b0;
      acen = 1'b0; cpl = 2'd0;
   endtask

   task automatic settle();
      @(posedge clk);
      #2;
   endtask

   task automatic t_idle();
      @(negedge clk);
      valid = 1'b0; lock = 1'b1; tsw = 1'b1;
      settle();
      check("R9 idle zero", 5'b00000, 1'b0);
   endtask

   task automatic t_clean_exec();
      for (int w = 0; w < 2; w++) begin
         clean(w[0]);
         settle();
         check("R9 exec on no fault", 5'b00000, 1'b1);
      end
   endtask

   task automatic t_undef();
      for (int w = 0; w < 2; w++) begin
         clean(w[0]); lock = 1'b1; settle();
         check("R1 lock", 5'b00001, 1'b0);
         clean(w[0]); emul = 1'b1; settle();
         check("R2 emul", 5'b00001, 1'b0);
      end
      clean(1'b1); osx = 1'b0; settle();
      check("R3 wide osx clear", 5'b00001, 1'b0);
      clean(1'b1); sok = 1'b0; settle();
      check("R3 wide feature clear", 5'b00001, 1'b0);
      clean(1'b0); osx = 1'b0; sok = 1'b0; settle();
      check("R3 narrow ignores support bits", 5'b00000, 1'b1);
   endtask

   task automatic t_nodev();
      for (int w = 0; w < 2; w++) begin
         clean(w[0]); tsw = 1'b1; settle();
         check("R4 task switched", 5'b00010, 1'b0);
      end
   endtask

   task automatic t_fpu();
      clean(1'b0); fpp = 1'b1; settle();
      check("R5 narrow fpu pending", 5'b00100, 1'b0);
      clean(1'b1); fpp = 1'b1; settle();
      check("R5 wide ignores fpu pending", 5'b00000, 1'b1);
   endtask

   task automatic t_wide_align();
      clean(1'b1); mem = 1'b1; addr = 64'h1000; settle();
      check("R6 wide aligned", 5'b00000, 1'b1);
      clean(1'b1); mem = 1'b1; addr = 64'h1008; settle();
      check("R6 wide off by 8", 5'b01000, 1'b0);
      clean(1'b1); mem = 1'b1; addr = 64'h1003; acen = 1'b1; cpl = 2'd3; settle();
      check("R6 wide gp not ac", 5'b01000, 1'b0);
      clean(1'b1); mem = 1'b0; addr = 64'h1003; settle();
      check("R6 register operand ignores address", 5'b00000, 1'b1);
   endtask

   task automatic t_narrow_align();
      clean(1'b0); mem = 1'b1; addr = 64'h2008; acen = 1'b1; cpl = 2'd3; settle();
      check("R7 narrow 8-aligned", 5'b00000, 1'b1);
      clean(1'b0); mem = 1'b1; addr = 64'h2004; acen = 1'b1; cpl = 2'd3; settle();
      check("R7 narrow misaligned user", 5'b10000, 1'b0);
      clean(1'b0); mem = 1'b1; addr = 64'h2004; acen = 1'b0; cpl = 2'd3; settle();
      check("R7 check disabled", 5'b00000, 1'b1);
      for (int p = 0; p < 3; p++) begin
         clean(1'b0); mem = 1'b1; addr = 64'h2001; acen = 1'b1; cpl = p[1:0]; settle();
         check("R7 privileged level", 5'b00000, 1'b1);
      end
   endtask

   task automatic t_priority();
      clean(1'b0); lock = 1'b1; tsw = 1'b1; fpp = 1'b1;
      mem = 1'b1; addr = 64'h3; acen = 1'b1; cpl = 2'd3; settle();
      check("R8 undef wins all", 5'b00001, 1'b0);
      clean(1'b0); tsw = 1'b1; fpp = 1'b1; settle();
      check("R8 nodev over fpu", 5'b00010, 1'b0);
      clean(1'b0); fpp = 1'b1; mem = 1'b1; addr = 64'h5; acen = 1'b1; cpl = 2'd3; settle();
      check("R8 fpu over align", 5'b00100, 1'b0);
      clean(1'b1); tsw = 1'b1; mem = 1'b1; addr = 64'h7; settle();
      check("R8 nodev over gp", 5'b00010, 1'b0);
      clean(1'b1); sok = 1'b0; mem = 1'b1; addr = 64'h7; settle();
      check("R8 undef over gp", 5'b00001, 1'b0);
      @(negedge clk); valid = 1'b0; settle();
      check("R9 valid drop clears", 5'b00000, 1'b0);
   endtask

   bit done = 1'b0;

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      valid = 1'b0; wide = 1'b0; mem = 1'b0; addr = '0; lock = 1'b0;
      emul = 1'b0; tsw = 1'b0; osx = 1'b1; sok = 1'b1; fpp = 1'b0;
      acen = 1'b0; cpl = 2'd0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      #2;
      check("R9 reset state", 5'b00000, 1'b0);
      t_idle();
      t_clean_exec();
      t_undef();
      t_nodev();
      t_fpu();
      t_wide_align();
      t_narrow_align();
      t_priority();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule